// File: doc/BRIEF.md
# Sixteen-Operation Register-Operand Execute Stage

This block is the execute stage of a small four-stage, 16-bit processor pipeline. Each cycle it receives a 4-bit opcode, two 4-bit source register numbers, a 4-bit destination register number and a 5-bit data memory address from the decode stage. It also receives the current contents of all sixteen 16-bit registers as one flat bus. Two independent 16-way selectors pick operand A and operand B from that bus. A combinational operation unit then forms one of sixteen results, and the stage captures that result in a result register.

The same clock edge also registers the controls for the rest of the pipeline. These are: a register-write strobe, a select that makes the register file take memory read data instead of the result, a data memory enable, a memory write strobe, and the destination and memory addresses. The result register output does two jobs. It is the register file write data, and it is also the memory write data for a store. Every output therefore reflects the inputs presented one clock earlier.

Top module: `exu_core`

## Requirements
- R1: While reset (rst_n low) is held, every output is 0.
- R2: Opcode 1 gives A+B, 2 gives A-B, 6 gives A+1 and 7 gives A-1, all modulo 2^16, on result_o one clock after the opcode is presented.
- R3: Opcode 3 gives A AND B, 4 gives A OR B, 5 gives A XOR B, and 8 gives the bitwise inverse of A.
- R4: Opcode 9 gives the two's complement negation of A, and the negation of 0x0000 is 0x0000.
- R5: Opcode 10 shifts A right by one bit and opcode 11 shifts A left by one bit, with the vacated bit filled with 0 (0x0044 becomes 0x0022).
- R6: Opcode 12 rotates A right by one bit, with bit 0 moving to bit 15. Opcode 13 rotates A left by one bit, with bit 15 moving to bit 0 (0x00FF becomes 0x01FE).
- R7: Register k sits at bits [16k+15:16k] of regs_i. Operand A is register a_sel_i and operand B is register b_sel_i, each chosen independently, and the two selectors may name the same register.
- R8: reg_wr_o is 1 for opcodes 1 through 14 and 0 for opcodes 0 and 15.
- R9: load_sel_o is 1 only for opcode 14 (load).
- R10: mem_en_o is 1 for opcodes 14 and 15. mem_we_o is 1 only for opcode 15 (store). mem_addr_o is the registered mem_addr_i.
- R11: For opcode 15, result_o equals operand A, which is the store data. For opcodes 0 and 14, result_o is 0.
- R12: wr_dst_o is the registered dst_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Opcode |
| a_sel_i | input | 4 | Operand A register number |
| b_sel_i | input | 4 | Operand B register number |
| dst_i | input | 4 | Destination register number |
| mem_addr_i | input | 5 | Data memory address for load or store |
| regs_i | input | 256 | Sixteen register values, register k in bits [16k+15:16k] |
| result_o | output | 16 | Result register, used as register write data and memory write data |
| wr_dst_o | output | 4 | Registered destination register number |
| reg_wr_o | output | 1 | Register file write strobe |
| load_sel_o | output | 1 | Register file takes memory read data instead of result_o |
| mem_en_o | output | 1 | Data memory access enable |
| mem_we_o | output | 1 | Data memory write strobe, 0 means read |
| mem_addr_o | output | 5 | Registered data memory address |

## Verification
Two operand selections can land in the same cycle. When a_sel_i and b_sel_i name the same register, both selectors must return that one value without interfering with each other. The sweep provokes this every time its index pattern makes the two numbers equal, and a subtraction of a register from itself must then give exactly zero. A second overlap is the store, where the data path and the memory controls act together: in the same captured cycle, result_o must carry operand A while mem_we_o is raised and reg_wr_o is dropped. Each vector is judged against a reference model that the bench computes arithmetically from the opcode table.

// File: rtl/exu_pkg.sv
package exu_pkg;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_INC  = 4'd6,
        OP_DEC  = 4'd7,
        OP_INV  = 4'd8,
        OP_NEG  = 4'd9,
        OP_SHR  = 4'd10,
        OP_SHL  = 4'd11,
        OP_ROR  = 4'd12,
        OP_ROL  = 4'd13,
        OP_LOAD = 4'd14,
        OP_STOR = 4'd15
    } exu_op_e;

    typedef struct packed {
        logic reg_wr;
        logic load_sel;
        logic mem_en;
        logic mem_we;
    } exu_ctrl_t;

endpackage

// File: rtl/exu_operand_mux.sv
module exu_operand_mux #(
    parameter int W  = 16,
    parameter int N  = 16,
    localparam int SW = $clog2(N)
) (
    input  logic [N*W-1:0] bus_i,
    input  logic [SW-1:0]  sel_i,
    output logic [W-1:0]   word_o
);

    logic [W-1:0] slot [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        assign slot[g] = bus_i[g*W +: W];
    end

    always_comb begin
        word_o = slot[sel_i];
    end

endmodule

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
#(
    parameter int W = 16
) (
    input  exu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);

    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        y_o = '0;
        unique case (op_i)
            OP_NOP:  y_o = '0;
            OP_ADD:  y_o = a_i + b_i;
            OP_SUB:  y_o = a_i - b_i;
            OP_AND:  y_o = a_i & b_i;
            OP_OR:   y_o = a_i | b_i;
            OP_XOR:  y_o = a_i ^ b_i;
            OP_INC:  y_o = a_i + ONE;
            OP_DEC:  y_o = a_i - ONE;
            OP_INV:  y_o = ~a_i;
            OP_NEG:  y_o = (~a_i) + ONE;
            OP_SHR:  y_o = {1'b0, a_i[W-1:1]};
            OP_SHL:  y_o = {a_i[W-2:0], 1'b0};
            OP_ROR:  y_o = {a_i[0], a_i[W-1:1]};
            OP_ROL:  y_o = {a_i[W-2:0], a_i[W-1]};
            OP_LOAD: y_o = '0;
            OP_STOR: y_o = a_i;
            default: y_o = '0;
        endcase
    end

endmodule

// File: rtl/exu_ctrl.sv
module exu_ctrl
    import exu_pkg::*;
(
    input  exu_op_e   op_i,
    output exu_ctrl_t ctrl_o
);

    always_comb begin
        ctrl_o = '0;
        unique case (op_i)
            OP_NOP: begin
                ctrl_o = '0;
            end
            OP_LOAD: begin
                ctrl_o.reg_wr   = 1'b1;
                ctrl_o.load_sel = 1'b1;
                ctrl_o.mem_en   = 1'b1;
            end
            OP_STOR: begin
                ctrl_o.mem_en = 1'b1;
                ctrl_o.mem_we = 1'b1;
            end
            default: begin
                ctrl_o.reg_wr = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/exu_core.sv
module exu_core
    import exu_pkg::*;
#(
    parameter int W  = 16,
    parameter int N  = 16,
    parameter int AW = 5,
    localparam int SW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [3:0]     op_i,
    input  logic [SW-1:0]  a_sel_i,
    input  logic [SW-1:0]  b_sel_i,
    input  logic [SW-1:0]  dst_i,
    input  logic [AW-1:0]  mem_addr_i,
    input  logic [N*W-1:0] regs_i,
    output logic [W-1:0]   result_o,
    output logic [SW-1:0]  wr_dst_o,
    output logic           reg_wr_o,
    output logic           load_sel_o,
    output logic           mem_en_o,
    output logic           mem_we_o,
    output logic [AW-1:0]  mem_addr_o
);

    typedef struct packed {
        logic [W-1:0]  result;
        logic [SW-1:0] dst;
        logic [AW-1:0] maddr;
        exu_ctrl_t     ctrl;
    } exu_stage_t;

    exu_op_e      op;
    logic [W-1:0] opnd_a;
    logic [W-1:0] opnd_b;
    logic [W-1:0] alu_y;
    exu_ctrl_t    ctrl;
    exu_stage_t   stage_d;
    exu_stage_t   stage_q;

    assign op = exu_op_e'(op_i);

    exu_operand_mux #(.W(W), .N(N)) u_mux_a (
        .bus_i (regs_i),
        .sel_i (a_sel_i),
        .word_o(opnd_a)
    );

    exu_operand_mux #(.W(W), .N(N)) u_mux_b (
        .bus_i (regs_i),
        .sel_i (b_sel_i),
        .word_o(opnd_b)
    );

    exu_alu #(.W(W)) u_alu (
        .op_i(op),
        .a_i (opnd_a),
        .b_i (opnd_b),
        .y_o (alu_y)
    );

    exu_ctrl u_ctrl (
        .op_i  (op),
        .ctrl_o(ctrl)
    );

    always_comb begin
        stage_d        = stage_q;
        stage_d.result = alu_y;
        stage_d.dst    = dst_i;
        stage_d.maddr  = mem_addr_i;
        stage_d.ctrl   = ctrl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign result_o   = stage_q.result;
    assign wr_dst_o   = stage_q.dst;
    assign mem_addr_o = stage_q.maddr;
    assign reg_wr_o   = stage_q.ctrl.reg_wr;
    assign load_sel_o = stage_q.ctrl.load_sel;
    assign mem_en_o   = stage_q.ctrl.mem_en;
    assign mem_we_o   = stage_q.ctrl.mem_we;

    // R2: a register subtracted from itself yields zero
    a_r2_sub_self_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd2 && a_sel_i == b_sel_i) |=> (result_o == '0));

    // R4: negation result plus original operand wraps to zero
    a_r4_neg_sum_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd9) |=> ((result_o + $past(opnd_a)) == '0));

    // R8: no register write after NOP or store
    a_r8_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd0 || op_i == 4'd15) |=> !reg_wr_o);

    // R9: load select only comes with a memory read that writes a register
    a_r9_load_pair: assert property (@(posedge clk) disable iff (!rst_n)
        load_sel_o |-> (reg_wr_o && mem_en_o && !mem_we_o));

    // R10: a memory write is always enabled and never writes a register
    a_r10_we_en: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_en_o && !reg_wr_o && !load_sel_o));

    // R11: store data is operand A of the store cycle
    a_r11_store_data: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd15) |=> (result_o == $past(opnd_a)));

endmodule

// File: tb/tb_exu_core.sv
`timescale 1ns/1ps
module tb_exu_core;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   op_i = '0;
    logic [3:0]   a_sel_i = '0;
    logic [3:0]   b_sel_i = '0;
    logic [3:0]   dst_i = '0;
    logic [4:0]   mem_addr_i = '0;
    logic [255:0] regs_i = '0;
    logic [15:0]  result_o;
    logic [3:0]   wr_dst_o;
    logic         reg_wr_o, load_sel_o, mem_en_o, mem_we_o;
    logic [4:0]   mem_addr_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;
    logic [15:0] rv [16];

    always #2.5 clk = ~clk;

    exu_core dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_sel_i(a_sel_i), .b_sel_i(b_sel_i),
        .dst_i(dst_i), .mem_addr_i(mem_addr_i), .regs_i(regs_i), .result_o(result_o),
        .wr_dst_o(wr_dst_o), .reg_wr_o(reg_wr_o), .load_sel_o(load_sel_o),
        .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o)
    );

    task automatic cmp(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input int op, input logic [15:0] a, input logic [15:0] b);
        case (op)
            1:  return a + b;
            2:  return a - b;
            3:  return a & b;
            4:  return a | b;
            5:  return a ^ b;
            6:  return a + 16'd1;
            7:  return a - 16'd1;
            8:  return ~a;
            9:  return 16'd0 - a;
            10: return a >> 1;
            11: return a << 1;
            12: return {a[0], a[15:1]};
            13: return {a[14:0], a[15]};
            15: return a;
            default: return 16'd0;
        endcase
    endfunction

    function automatic string res_tag(input int op);
        case (op)
            1, 2, 6, 7:  return "R2";
            3, 4, 5, 8:  return "R3";
            9:           return "R4";
            10, 11:      return "R5";
            12, 13:      return "R6";
            default:     return "R11";
        endcase
    endfunction

    task automatic load_regs();
        for (int k = 0; k < 16; k++) regs_i[k*16 +: 16] = rv[k];
    endtask

    // drive at negedge, sample at the negedge after the capturing posedge
    task automatic apply(input int op, input int a, input int b, input int d, input int ma);
        op_i = 4'(op); a_sel_i = 4'(a); b_sel_i = 4'(b); dst_i = 4'(d); mem_addr_i = 5'(ma);
        @(posedge clk);
        @(negedge clk);
        cmp({res_tag(op), " result"}, result_o, model(op, rv[a], rv[b]));
        cmp("R8 reg_wr", 16'(reg_wr_o), 16'(op != 0 && op != 15));
        cmp("R9 load_sel", 16'(load_sel_o), 16'(op == 14));
        cmp("R10 mem_en", 16'(mem_en_o), 16'(op >= 14));
        cmp("R10 mem_we", 16'(mem_we_o), 16'(op == 15));
        cmp("R10 mem_addr", 16'(mem_addr_o), 16'(ma));
        cmp("R12 wr_dst", 16'(wr_dst_o), 16'(d));
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rv[0] = 16'h0000; rv[1] = 16'h0044; rv[2] = 16'h00FF; rv[3] = 16'h8000;
        rv[4] = 16'h0001; rv[5] = 16'hFFFF; rv[6] = 16'h1234; rv[7] = 16'hA5A5;
        for (int k = 8; k < 16; k++) rv[k] = 16'((k * 16'h1111) ^ 16'h0F0F);
        load_regs();
        op_i = 4'd1; dst_i = 4'd9; mem_addr_i = 5'd17;
        repeat (3) @(negedge clk);
        // R1: outputs held at zero during reset despite active inputs
        cmp("R1 result", result_o, 16'h0);
        cmp("R1 controls", {12'd0, reg_wr_o, load_sel_o, mem_en_o, mem_we_o}, 16'h0);
        cmp("R1 addrs", {7'd0, wr_dst_o, mem_addr_o}, 16'h0);
        rst_n = 1'b1;

        // directed corners
        apply(9, 0, 0, 1, 0);   cmp("R4 neg zero", result_o, 16'h0000);
        apply(10, 1, 0, 2, 0);  cmp("R5 shr 0044", result_o, 16'h0022);
        apply(11, 3, 0, 2, 0);  cmp("R5 shl msb lost", result_o, 16'h0000);
        apply(13, 2, 0, 3, 0);  cmp("R6 rol 00FF", result_o, 16'h01FE);
        apply(12, 4, 0, 3, 0);  cmp("R6 ror lsb wraps", result_o, 16'h8000);
        apply(13, 3, 0, 3, 0);  cmp("R6 rol msb wraps", result_o, 16'h0001);
        apply(1, 5, 4, 4, 0);   cmp("R2 add wraps", result_o, 16'h0000);
        apply(7, 0, 0, 4, 0);   cmp("R2 dec wraps", result_o, 16'hFFFF);
        apply(2, 6, 6, 5, 0);   cmp("R7 same register both sides", result_o, 16'h0000);
        apply(2, 1, 2, 5, 0);   cmp("R7 independent A/B", result_o, 16'hFF45);
        apply(15, 7, 2, 6, 31); cmp("R11 store data", result_o, 16'hA5A5);
        apply(14, 7, 2, 6, 30); cmp("R11 load result", result_o, 16'h0000);

        // sweep: every opcode, every A register, B register pattern varied per seed
        for (int seed = 0; seed < 8; seed++) begin
            if (seed > 0)
                for (int k = 0; k < 16; k++)
                    rv[k] = 16'((seed * 16'h9E37) ^ (k * 16'h3B1D) ^ (k << seed));
            load_regs();
            for (int op = 0; op < 16; op++)
                for (int a = 0; a < 16; a++)
                    apply(op, a, (a * 7 + seed) & 15, (a + op) & 15, (a * 3 + seed + op) & 31);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule